// File: doc/BRIEF.md
# Descriptor Mailbox Register Block

This block is the device-side register window through which a host passes descriptor addresses to a disk controller and gets completed ones back. The host sees seven byte-wide registers: four address bytes, an address-mode byte, a control/status byte and a fatal-code byte. To post work, the host loads the 32-bit address, then sets the add bit in the control/status byte. The block takes a snapshot of the address and offers it to the controller back end through a valid/ready channel. At most a parameterised number of descriptors (31 by default) may be outstanding at once.

Finished descriptors arrive from the back end on a second valid/ready channel and go into a small completion queue. The block hands them to the host one at a time. It loads the finished address into the same four address bytes and raises a remove flag. The host acknowledges by writing the remove bit, and that frees one outstanding slot. A soft reset bit flushes all state and holds the block busy for a fixed number of cycles. A misaligned add is refused and latches a fatal code.

Top module: `mbx_regfile`

## Requirements
- R1: Registers sit at byte offsets 1, 3, 5 and 7 (address bytes, least significant first), 9 (address mode, reset value 0x3D), 11 (control/status) and 13 (fatal code). Every other offset reads 0. After reset, all registers read 0 except the address mode.
- R2: Writing the control/status byte with bit 2 set, while no add is pending and the address is 4-byte aligned, snapshots the address and raises `add_valid`. Bit 2 reads 1 until the back end accepts with `add_ready`. `add_addr` stays stable while it waits. A further add write while one is pending is ignored.
- R3: If the address mode byte is 0x0D when the add is written, the full 32-bit address is issued. Any other value (0x3D is the default) issues only the low 24 bits, with bits 31:24 forced to 0. `add_amod` carries the mode byte captured with the add.
- R4: While MAX_OUT descriptors are outstanding, a new add stays pending: bit 2 reads 1 and `add_valid` stays low. It issues once a remove acknowledge frees a slot.
- R5: When the remove flag (bit 1) is clear and the completion queue is not empty, the oldest completion is loaded into the four address bytes on the next clock and bit 1 reads 1. Completions are presented one at a time, in arrival order.
- R6: Writing the control/status byte with bit 1 set clears a set remove flag and frees one outstanding slot. The next queued completion is presented one clock later. While the flag stays set and the host does not write, the address bytes do not change.
- R7: `cpl_ready` is low while the completion queue holds CQ_DEPTH entries.
- R8: An add request whose address has bits 1:0 non-zero is not queued. Instead it sets bit 6 and loads the fatal code 0xF2. The first code is kept, and only a soft reset clears it.
- R9: Bit 7 ignores writes. On read, bit 7 is busy: soft reset in progress, an add pending, or any descriptor outstanding.
- R10: Every control/status write loads bit 5 (maintenance) and bit 0 (semaphore) from the written data, and both read back.
- R11: A control/status write with bit 3 set clears all state, the queue and the fatal latch, and restores the address mode to 0x3D. For RST_CYCLES cycles after that, bits 3 and 7 read 1, host writes are ignored, and both back-end channels are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register byte offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for `reg_addr` |
| add_valid | output | 1 | Descriptor address offered to back end |
| add_ready | input | 1 | Back end takes the offered address |
| add_addr | output | 32 | Offered descriptor address |
| add_amod | output | 8 | Address mode captured with the add |
| cpl_valid | input | 1 | Back end returns a completed address |
| cpl_ready | output | 1 | Completion queue can accept |
| cpl_addr | input | 32 | Completed descriptor address |

## Verification
The hardest state to reach is a full outstanding window. The bench resets the block, then posts thirty-one aligned adds back to back with the back end always ready. The thirty-second add must then sit pending. A single completion is returned and acknowledged, and the stalled add must leave in the very next cycle. The full completion queue is reached by returning five completions while the host leaves the first one unacknowledged. A behavioural model built from queues and counters predicts every output and the read data on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_AMODE = 4'd9;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 4'd11;
  localparam logic [REG_AW-1:0] OFS_FCODE = 4'd13;

  // control/status bit positions
  localparam int CB_SEM   = 0;
  localparam int CB_REM   = 1;
  localparam int CB_ADD   = 2;
  localparam int CB_SRST  = 3;
  localparam int CB_MAINT = 5;
  localparam int CB_FATAL = 6;
  localparam int CB_BUSY  = 7;

  localparam logic [7:0] AMODE_NARROW = 8'h3D;
  localparam logic [7:0] AMODE_WIDE   = 8'h0D;
  localparam logic [7:0] FCODE_ALIGN  = 8'hF2;
endpackage

// File: rtl/mbx_cplq.sv
module mbx_cplq #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = bump(wp_q);
      if (pop)  rp_d = bump(rp_q);
      if (push && !pop)      cnt_d = cnt_q + CW'(1);
      else if (pop && !push) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !flush && wp_q == PW'(i)) mem[i] <= din;
    end
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/mbx_srst_timer.sv
module mbx_srst_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = CW'(CYCLES - 1);
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/mbx_issue.sv
module mbx_issue #(
  parameter int AW       = 32,
  parameter int NARROW_W = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_amod,
  input  logic          hold,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [7:0]    amod,
  output logic          pending,
  output logic          accept
);
  import mbx_pkg::*;

  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    amod_q, amod_d;

  assign valid  = pend_q && !hold;
  assign accept = valid && ready;

  always_comb begin
    pend_d = pend_q;
    addr_d = addr_q;
    amod_d = amod_q;
    if (flush) begin
      pend_d = 1'b0;
    end else if (req) begin
      pend_d = 1'b1;
      amod_d = req_amod;
      addr_d = (req_amod == AMODE_WIDE) ? req_addr : (req_addr & NARROW_MASK);
    end else if (accept) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      amod_q <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      amod_q <= amod_d;
    end
  end

  assign addr    = addr_q;
  assign amod    = amod_q;
  assign pending = pend_q;
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int MAX_OUT    = 31,
  parameter int CQ_DEPTH   = 4,
  parameter int RST_CYCLES = 16,
  parameter int AW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          add_valid,
  input  logic          add_ready,
  output logic [AW-1:0] add_addr,
  output logic [7:0]    add_amod,
  input  logic          cpl_valid,
  output logic          cpl_ready,
  input  logic [AW-1:0] cpl_addr
);
  import mbx_pkg::*;

  localparam int NBYTES = AW / 8;
  localparam int OW     = $clog2(MAX_OUT + 1);

  logic          resetting, srst_go, wr_ok, ctrl_wr;
  logic          add_raw, misalign, add_req, fatal_set;
  logic          clr, pop, push, accept, pending;
  logic          q_empty, q_full;
  logic [AW-1:0] q_dout, addr_q;
  logic [7:0]    amod_q, amod_d;
  logic          maint_q, maint_d, sem_q, sem_d;
  logic          rem_q, rem_d, fatal_q, fatal_d;
  logic [7:0]    fcode_q, fcode_d;
  logic [OW-1:0] outst_q, outst_d;
  logic          outst_full, busy;
  logic [7:0]    ctrl_rd;

  // host-side decode
  assign wr_ok     = reg_wr && !resetting;
  assign srst_go   = wr_ok && (reg_addr == OFS_CTRL) && reg_wdata[CB_SRST];
  assign ctrl_wr   = wr_ok && (reg_addr == OFS_CTRL) && !reg_wdata[CB_SRST];
  assign add_raw   = ctrl_wr && reg_wdata[CB_ADD] && !pending;
  assign misalign  = (addr_q[1:0] != 2'b00);
  assign add_req   = add_raw && !misalign;
  assign fatal_set = add_raw && misalign;
  assign clr       = ctrl_wr && reg_wdata[CB_REM] && rem_q;
  assign pop       = !rem_q && !q_empty && !resetting;
  assign cpl_ready = !q_full && !resetting;
  assign push      = cpl_valid && cpl_ready;
  assign outst_full = (outst_q >= OW'(MAX_OUT));

  mbx_srst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(srst_go), .active(resetting)
  );

  mbx_cplq #(.W(AW), .DEPTH(CQ_DEPTH)) u_cplq (
    .clk(clk), .rst_n(rst_n), .flush(srst_go), .push(push), .din(cpl_addr),
    .pop(pop), .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  mbx_issue #(.AW(AW)) u_issue (
    .clk(clk), .rst_n(rst_n), .flush(srst_go), .req(add_req),
    .req_addr(addr_q), .req_amod(amod_q), .hold(outst_full || resetting),
    .ready(add_ready), .valid(add_valid), .addr(add_addr), .amod(add_amod),
    .pending(pending), .accept(accept)
  );

  // address bytes: shared by host posting and completion return
  for (genvar g = 0; g < NBYTES; g++) begin : g_abyte
    localparam logic [3:0] OFS = 4'(2 * g + 1);
    logic [7:0] b_q, b_d;
    always_comb begin
      b_d = b_q;
      if (srst_go)                     b_d = '0;
      else if (pop)                    b_d = q_dout[8*g +: 8];
      else if (wr_ok && reg_addr == OFS) b_d = reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_q <= '0;
      else        b_q <= b_d;
    end
    assign addr_q[8*g +: 8] = b_q;
  end

  always_comb begin
    amod_d  = amod_q;
    maint_d = maint_q;
    sem_d   = sem_q;
    rem_d   = rem_q;
    fatal_d = fatal_q;
    fcode_d = fcode_q;
    outst_d = outst_q;
    if (srst_go) begin
      amod_d  = AMODE_NARROW;
      maint_d = 1'b0;
      sem_d   = 1'b0;
      rem_d   = 1'b0;
      fatal_d = 1'b0;
      fcode_d = '0;
      outst_d = '0;
    end else begin
      if (wr_ok && reg_addr == OFS_AMODE) amod_d = reg_wdata;
      if (ctrl_wr) begin
        maint_d = reg_wdata[CB_MAINT];
        sem_d   = reg_wdata[CB_SEM];
      end
      if (pop)      rem_d = 1'b1;
      else if (clr) rem_d = 1'b0;
      if (fatal_set && !fatal_q) begin
        fatal_d = 1'b1;
        fcode_d = FCODE_ALIGN;
      end
      outst_d = outst_q + OW'(accept) - OW'(clr && outst_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amod_q  <= AMODE_NARROW;
      maint_q <= 1'b0;
      sem_q   <= 1'b0;
      rem_q   <= 1'b0;
      fatal_q <= 1'b0;
      fcode_q <= '0;
      outst_q <= '0;
    end else begin
      amod_q  <= amod_d;
      maint_q <= maint_d;
      sem_q   <= sem_d;
      rem_q   <= rem_d;
      fatal_q <= fatal_d;
      fcode_q <= fcode_d;
      outst_q <= outst_d;
    end
  end

  // read side
  assign busy = resetting || pending || (outst_q != '0);

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[CB_BUSY]  = busy;
    ctrl_rd[CB_FATAL] = fatal_q;
    ctrl_rd[CB_MAINT] = maint_q;
    ctrl_rd[CB_SRST]  = resetting;
    ctrl_rd[CB_ADD]   = pending;
    ctrl_rd[CB_REM]   = rem_q;
    ctrl_rd[CB_SEM]   = sem_q;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (reg_addr == 4'(2 * i + 1)) reg_rdata = addr_q[8*i +: 8];
    end
    if (reg_addr == OFS_AMODE) reg_rdata = amod_q;
    if (reg_addr == OFS_CTRL)  reg_rdata = ctrl_rd;
    if (reg_addr == OFS_FCODE) reg_rdata = fcode_q;
  end
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk #(
  parameter int MAX_OUT = 31,
  parameter int OW      = 5,
  parameter int AW      = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          add_valid,
  input logic          add_ready,
  input logic [AW-1:0] add_addr,
  input logic [7:0]    add_amod,
  input logic          cpl_ready,
  input logic          resetting,
  input logic          rem_q,
  input logic [AW-1:0] addr_q,
  input logic          fatal_q,
  input logic [OW-1:0] outst_q
);
  AST_ADD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid && !add_ready && !reg_wr |=> add_valid && $stable(add_addr)); // R2

  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid && add_amod != 8'h0D |-> add_addr[AW-1:24] == '0); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    add_valid |-> outst_q < OW'(MAX_OUT)); // R4

  AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q && !reg_wr |=> rem_q && $stable(addr_q)); // R6

  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_q && !reg_wr |=> fatal_q); // R8

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> !add_valid && !cpl_ready); // R11
endmodule

bind mbx_regfile mbx_regfile_chk #(.MAX_OUT(MAX_OUT), .OW(OW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .add_valid(add_valid),
  .add_ready(add_ready), .add_addr(add_addr), .add_amod(add_amod),
  .cpl_ready(cpl_ready), .resetting(resetting), .rem_q(rem_q),
  .addr_q(addr_q), .fatal_q(fatal_q), .outst_q(outst_q)
);

// File: tb/mbx_regfile_tb_top.sv
module mbx_regfile_tb_top;
  localparam int MAXO = 31;
  localparam int CQD  = 4;
  localparam int RSTC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        add_valid, add_ready = 1'b1;
  logic [31:0] add_addr;
  logic [7:0]  add_amod;
  logic        cpl_valid = 1'b0, cpl_ready;
  logic [31:0] cpl_addr = '0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mbx_regfile #(.MAX_OUT(MAXO), .CQ_DEPTH(CQD), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .add_valid(add_valid),
    .add_ready(add_ready), .add_addr(add_addr), .add_amod(add_amod),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_addr(cpl_addr)
  );

  // ---------------- reference model ----------------
  int          m_rleft, m_outst;
  bit          m_pend, m_rem, m_maint, m_sem, m_fat;
  logic [31:0] m_paddr, m_addr;
  logic [7:0]  m_pamod, m_amod, m_fcode;
  logic [31:0] m_q[$];

  function automatic bit e_add_valid();
    return m_pend && m_outst < MAXO && m_rleft == 0;
  endfunction
  function automatic bit e_cpl_ready();
    return m_q.size() < CQD && m_rleft == 0;
  endfunction
  function automatic logic [7:0] e_read(input logic [3:0] a);
    case (a)
      4'd1: return m_addr[7:0];
      4'd3: return m_addr[15:8];
      4'd5: return m_addr[23:16];
      4'd7: return m_addr[31:24];
      4'd9: return m_amod;
      4'd11: return {(m_rleft > 0 || m_pend || m_outst != 0), m_fat, m_maint, 1'b0,
                     (m_rleft > 0), m_pend, m_rem, m_sem};
      4'd13: return m_fcode;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_clear();
    m_pend = 0; m_rem = 0; m_maint = 0; m_sem = 0; m_fat = 0;
    m_outst = 0; m_addr = '0; m_amod = 8'h3D; m_fcode = '0; m_q.delete();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear();
      m_rleft = 0;
      m_paddr = '0;
      m_pamod = '0;
    end else if (m_rleft > 0) begin
      m_rleft = m_rleft - 1;
    end else if (reg_wr && reg_addr == 4'd11 && reg_wdata[3]) begin
      m_clear();
      m_rleft = RSTC;
    end else begin
      bit acc, push, pop, cw, clr, pend_old;
      int outst_old;
      logic [31:0] addr_old;
      logic [7:0]  amod_old;
      acc = e_add_valid() && add_ready;
      push = cpl_valid && e_cpl_ready();
      pop = !m_rem && m_q.size() > 0;
      cw = reg_wr && reg_addr == 4'd11;
      clr = cw && reg_wdata[1] && m_rem;
      pend_old = m_pend; outst_old = m_outst; addr_old = m_addr; amod_old = m_amod;
      if (acc) begin m_pend = 0; m_outst = m_outst + 1; end
      if (clr && outst_old > 0) m_outst = m_outst - 1;
      if (reg_wr) begin
        case (reg_addr)
          4'd1: m_addr[7:0] = reg_wdata;
          4'd3: m_addr[15:8] = reg_wdata;
          4'd5: m_addr[23:16] = reg_wdata;
          4'd7: m_addr[31:24] = reg_wdata;
          4'd9: m_amod = reg_wdata;
          default: ;
        endcase
      end
      if (cw && reg_wdata[2] && !pend_old) begin
        if (addr_old[1:0] != 2'b00) begin
          if (!m_fat) begin m_fat = 1; m_fcode = 8'hF2; end
        end else begin
          m_pend = 1;
          m_pamod = amod_old;
          m_paddr = (amod_old == 8'h0D) ? addr_old : {8'h00, addr_old[23:0]};
        end
      end
      if (cw) begin m_maint = reg_wdata[5]; m_sem = reg_wdata[0]; end
      if (pop) begin m_addr = m_q.pop_front(); m_rem = 1; end
      else if (clr) m_rem = 0;
      if (push) m_q.push_back(cpl_addr);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R2 add_valid", 32'(add_valid), 32'(e_add_valid()));
      chk("R7 cpl_ready", 32'(cpl_ready), 32'(e_cpl_ready()));
      chk("R1 reg_rdata", 32'(reg_rdata), 32'(e_read(reg_addr)));
      if (e_add_valid()) begin
        chk("R3 add_addr", add_addr, m_paddr);
        chk("R3 add_amod", 32'(add_amod), 32'(m_pamod));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] mask,
                       input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, 32'(reg_rdata & mask), 32'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpl(input logic [31:0] v);
    @(negedge clk);
    while (!cpl_ready) @(negedge clk);
    cpl_valid = 1'b1; cpl_addr = v;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [31:0] v);
    wr(4'd1, v[7:0]); wr(4'd3, v[15:8]); wr(4'd5, v[23:16]); wr(4'd7, v[31:24]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    rdchk("R1 reset ctrl", 4'd11, 8'hFF, 8'h00);
    rdchk("R1 reset amode", 4'd9, 8'hFF, 8'h3D);
    rdchk("R1 reset fcode", 4'd13, 8'hFF, 8'h00);
    rdchk("R1 reset byte0", 4'd1, 8'hFF, 8'h00);
    // R1: address byte map, least significant first
    set_addr(32'h12345678);
    rdchk("R1 byte0", 4'd1, 8'hFF, 8'h78);
    rdchk("R1 byte3", 4'd7, 8'hFF, 8'h12);
    rdchk("R1 filler", 4'd2, 8'hFF, 8'h00);

    // R2/R3: narrow add held without ready
    add_ready = 1'b0;
    wr(4'd11, 8'h04);
    idle(3);
    chk("R2 held valid", 32'(add_valid), 32'd1);
    chk("R3 narrow addr", add_addr, 32'h00345678);
    rdchk("R2 pending bit", 4'd11, 8'h04, 8'h04);
    add_ready = 1'b1;
    idle(1);
    rdchk("R2 pending cleared", 4'd11, 8'h04, 8'h00);

    // R3: wide mode
    wr(4'd9, 8'h0D);
    set_addr(32'h9ABCDEF0);
    add_ready = 1'b0;
    wr(4'd11, 8'h04);
    idle(1);
    chk("R3 wide addr", add_addr, 32'h9ABCDEF0);
    chk("R3 wide amod", 32'(add_amod), 32'h0D);
    add_ready = 1'b1;
    idle(2);

    // R5/R6/R7: completion return
    cpl(32'hAAAA0004);
    idle(1);
    rdchk("R5 remove flag", 4'd11, 8'h02, 8'h02);
    rdchk("R5 byte0", 4'd1, 8'hFF, 8'h04);
    rdchk("R5 byte3", 4'd7, 8'hFF, 8'hAA);
    cpl(32'hBBBB0008); cpl(32'hCCCC000C); cpl(32'hDDDD0010); cpl(32'hEEEE0014);
    idle(1);
    chk("R7 queue full", 32'(cpl_ready), 32'd0);
    rdchk("R6 addr held", 4'd5, 8'hFF, 8'hAA);
    wr(4'd11, 8'h02);
    idle(1);
    rdchk("R6 next presented", 4'd7, 8'hFF, 8'hBB);
    rdchk("R6 flag again", 4'd11, 8'h02, 8'h02);
    chk("R7 room again", 32'(cpl_ready), 32'd1);

    // R8: misaligned add
    wr(4'd1, 8'h03);
    wr(4'd11, 8'h04);
    rdchk("R8 fatal bit", 4'd11, 8'h44, 8'h40);
    rdchk("R8 fatal code", 4'd13, 8'hFF, 8'hF2);
    idle(3);
    rdchk("R8 sticky", 4'd11, 8'h40, 8'h40);

    // R10: maintenance and semaphore bits
    wr(4'd11, 8'h21);
    rdchk("R10 bits set", 4'd11, 8'h21, 8'h21);
    wr(4'd11, 8'h00);
    rdchk("R10 bits clear", 4'd11, 8'h21, 8'h00);

    // R11: soft reset
    wr(4'd11, 8'h08);
    rdchk("R11 busy+srst", 4'd11, 8'hFF, 8'h88);
    chk("R11 cpl idle", 32'(cpl_ready), 32'd0);
    wr(4'd9, 8'h55);
    rdchk("R11 write ignored", 4'd9, 8'hFF, 8'h3D);
    idle(RSTC);
    rdchk("R11 ctrl after", 4'd11, 8'hFF, 8'h00);
    rdchk("R11 fcode after", 4'd13, 8'hFF, 8'h00);
    rdchk("R11 addr after", 4'd7, 8'hFF, 8'h00);

    // R9: bit 7 write ignored
    wr(4'd11, 8'h80);
    rdchk("R9 bit7 ignored", 4'd11, 8'hFF, 8'h00);

    // R4: outstanding limit
    set_addr(32'h00001000);
    for (int i = 0; i < MAXO; i++) begin
      wr(4'd11, 8'h04);
      idle(1);
    end
    rdchk("R9 busy outstanding", 4'd11, 8'h80, 8'h80);
    wr(4'd11, 8'h04);
    idle(2);
    chk("R4 stalled", 32'(add_valid), 32'd0);
    rdchk("R4 still pending", 4'd11, 8'h04, 8'h04);
    cpl(32'h00000100);
    idle(1);
    wr(4'd11, 8'h06);
    #1;
    chk("R4 issues after free", 32'(add_valid), 32'd1);
    idle(1);
    rdchk("R4 pending gone", 4'd11, 8'h04, 8'h00);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule